// File: doc/BRIEF.md
# UART Hardware Flow Controller

This block handles hardware flow control for a single UART channel. On the receive side it compares the receive FIFO fill count with two thresholds and drives an active-low ready-to-send line, `rts_no`. The line is asserted low while the FIFO has room. It goes high once the fill reaches the upper threshold. It stays high until the fill drops below the lower threshold, so the gap between the two thresholds gives hysteresis. A level interrupt reports that the fill has reached a separate trigger threshold.

Automatic ready-to-send control acts only after software has asserted the line through the manual control bit. With automatic control disabled, the line is a plain general-purpose output that follows that bit.

On the transmit side, the active-low clear-to-send input is synchronised. When automatic clear-to-send is enabled, it blocks the start of each new character while the line is high. A character that is already being shifted out is not cut short.

Top module: `uart_hw_flow_ctrl`

## Requirements
- R1: During and directly after reset, `rts_no` is 1, `rx_trig_irq_o` is 0 and the hysteresis state is cleared.
- R2: One clock after the edge that samples `rx_count_i >= trig_lvl_i`, `rx_trig_irq_o` is 1. Otherwise it is 0.
- R3: With `auto_rts_en_i`=1 and `rts_manual_i`=1, an edge that samples `rx_count_i >= hi_lvl_i` drives `rts_no` to 1 after that edge.
- R4: With auto mode and manual assert both active, `rts_no` holds its value while `lo_lvl_i <= rx_count_i < hi_lvl_i`. It returns to 0 after an edge that samples `rx_count_i < lo_lvl_i`.
- R5: When `rts_manual_i`=0 at an edge, `rts_no` is 1 after that edge, whatever auto mode and the fill count are.
- R6: When `auto_rts_en_i`=0 at an edge, `rts_no` equals the inverse of `rts_manual_i` after that edge, and the thresholds and count have no effect.
- R7: With `auto_cts_en_i`=1, `tx_start_o` is 0 whenever the value of `cts_ni` sampled two edges earlier is 1. `cts_ni` passes through a two-flop synchroniser that resets to 1.
- R8: With `auto_cts_en_i`=0, `tx_start_o` equals `tx_pending_i & tx_idle_i`, and `cts_ni` is ignored.
- R9: `tx_start_o` is 0 while `tx_idle_i` is 0. The clear-to-send gate only withholds the start of the next character.
- R10: Dropping auto mode or the manual bit clears the hysteresis state. After re-enabling with a count between the thresholds, `rts_no` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_rts_en_i | input | 1 | Enable automatic ready-to-send control |
| auto_cts_en_i | input | 1 | Enable automatic clear-to-send gating |
| rts_manual_i | input | 1 | Manual control bit; 1 asserts `rts_no` low |
| rx_count_i | input | CNT_W (7) | Receive FIFO fill count, 0..64 |
| trig_lvl_i | input | CNT_W (7) | Interrupt trigger threshold |
| hi_lvl_i | input | CNT_W (7) | Upper threshold that halts the sender |
| lo_lvl_i | input | CNT_W (7) | Lower threshold that resumes the sender; must be below `hi_lvl_i` |
| cts_ni | input | 1 | Clear-to-send, active low, asynchronous |
| tx_pending_i | input | 1 | Transmit holding data is waiting |
| tx_idle_i | input | 1 | Transmit shifter is idle |
| rts_no | output | 1 | Ready-to-send, active low |
| rx_trig_irq_o | output | 1 | Fill at or above trigger threshold |
| tx_start_o | output | 1 | Permission to start the next character |

## Verification
The receive hysteresis and the interrupt level can both change on the same edge when the trigger and upper thresholds are close or equal. A slow random walk of the fill count passes across both thresholds at once, and a reference model checks both outputs at every negative clock edge. A clear-to-send change can also coincide with a pending character becoming idle. Random toggling of `cts_ni` against `tx_idle_i` provokes this, and `tx_start_o` is judged against the input history two edges back.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  typedef enum logic {
    FLOW_GO   = 1'b0,
    FLOW_HALT = 1'b1
  } flow_state_e;

  function automatic int unsigned cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/fc_level_irq.sv
module fc_level_irq #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] trig_i,
  output logic             irq_o
);
  logic irq_q;
  logic past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q     <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      irq_q     <= (count_i >= trig_i);
      past_ok_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  assert_irq_at_trig_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(count_i >= trig_i) |-> irq_o);
  assert_irq_below_trig_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(count_i < trig_i) |-> !irq_o);
endmodule

// File: rtl/fc_rts_ctrl.sv
module fc_rts_ctrl
  import uart_fc_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_en_i,
  input  logic             manual_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             rts_no
);
  flow_state_e state_q, state_d;
  logic        rts_q;
  logic        past_ok_q;
  logic        armed;

  // auto mode only acts once software has asserted the line
  assign armed = auto_en_i & manual_i;

  always_comb begin
    state_d = state_q;
    if (!armed)                state_d = FLOW_GO;
    else if (count_i >= hi_i)  state_d = FLOW_HALT;
    else if (count_i < lo_i)   state_d = FLOW_GO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= FLOW_GO;
      rts_q     <= 1'b1;
      past_ok_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      rts_q     <= ~manual_i | (state_d == FLOW_HALT);
      past_ok_q <= 1'b1;
    end
  end

  assign rts_no = rts_q;

  assert_gpo_follows_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && !$past(auto_en_i) |-> rts_no == !$past(manual_i));
  assert_no_assert_without_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && !$past(manual_i) |-> rts_no);
  assert_halt_at_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(auto_en_i && manual_i && count_i >= hi_i) |-> rts_no);
  assert_resume_below_lower_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(auto_en_i && manual_i && count_i < lo_i && count_i < hi_i) |-> !rts_no);
  assert_hold_between_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(auto_en_i && manual_i) && auto_en_i && manual_i
      && count_i >= lo_i && count_i < hi_i |=> $stable(rts_no));
endmodule

// File: rtl/fc_cts_gate.sv
module fc_cts_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_en_i,
  input  logic cts_ni,
  input  logic pending_i,
  input  logic idle_i,
  output logic start_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else         sync_q[g] <= cts_ni;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  // gate only the start; an in-flight character is outside this block
  assign start_o = pending_i & idle_i & (~auto_en_i | ~sync_q[SYNC_STAGES-1]);

  assert_no_start_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |-> !start_o);

  if (SYNC_STAGES == 2) begin : g_chk
    logic [1:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            warm_q <= 2'd0;
      else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
    assert_cts_blocks_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      warm_q == 2'd2 && auto_en_i && $past(cts_ni, 2) |-> !start_o);
    assert_cts_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !auto_en_i && pending_i && idle_i |-> start_o);
  end
endmodule

// File: rtl/uart_hw_flow_ctrl.sv
module uart_hw_flow_ctrl
  import uart_fc_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 64,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = cnt_width(FIFO_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_rts_en_i,
  input  logic             auto_cts_en_i,
  input  logic             rts_manual_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] trig_lvl_i,
  input  logic [CNT_W-1:0] hi_lvl_i,
  input  logic [CNT_W-1:0] lo_lvl_i,
  input  logic             cts_ni,
  input  logic             tx_pending_i,
  input  logic             tx_idle_i,
  output logic             rts_no,
  output logic             rx_trig_irq_o,
  output logic             tx_start_o
);
  fc_level_irq #(.CNT_W(CNT_W)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (rx_count_i),
    .trig_i  (trig_lvl_i),
    .irq_o   (rx_trig_irq_o)
  );

  fc_rts_ctrl #(.CNT_W(CNT_W)) u_rts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .auto_en_i (auto_rts_en_i),
    .manual_i  (rts_manual_i),
    .count_i   (rx_count_i),
    .hi_i      (hi_lvl_i),
    .lo_i      (lo_lvl_i),
    .rts_no    (rts_no)
  );

  fc_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .auto_en_i (auto_cts_en_i),
    .cts_ni    (cts_ni),
    .pending_i (tx_pending_i),
    .idle_i    (tx_idle_i),
    .start_o   (tx_start_o)
  );
endmodule

// File: tb/uart_hw_flow_ctrl_tb.sv
module uart_hw_flow_ctrl_tb_top;
  localparam int CNT_W = 7;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic auto_rts_en_i = 1'b0, auto_cts_en_i = 1'b0, rts_manual_i = 1'b0;
  logic [CNT_W-1:0] rx_count_i = '0, trig_lvl_i = 7'd32, hi_lvl_i = 7'd48, lo_lvl_i = 7'd16;
  logic cts_ni = 1'b1, tx_pending_i = 1'b0, tx_idle_i = 1'b1;
  logic rts_no, rx_trig_irq_o, tx_start_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  uart_hw_flow_ctrl dut_i (.*);

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  bit m_halt = 1'b0, m_rts = 1'b1, m_irq = 1'b0, h1 = 1'b1, h2 = 1'b1;

  task automatic chk(input int act, input int exp, input string tag, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_start();
    return tx_pending_i & tx_idle_i & (!auto_cts_en_i | !h2);
  endfunction

  // called at a negedge after inputs were set; returns at the next negedge
  task automatic step();
    #1;
    chk(tx_start_o, exp_start(),
        !tx_idle_i ? "R9" : (auto_cts_en_i ? "R7" : "R8"), "tx_start_o");
    @(posedge clk_i); #1;
    m_irq = (rx_count_i >= trig_lvl_i);
    if (!auto_rts_en_i || !rts_manual_i) m_halt = 1'b0;
    else if (rx_count_i >= hi_lvl_i)     m_halt = 1'b1;
    else if (rx_count_i < lo_lvl_i)      m_halt = 1'b0;
    m_rts = !rts_manual_i | m_halt;
    h2 = h1; h1 = cts_ni;
    @(negedge clk_i);
    chk(rx_trig_irq_o, m_irq, "R2", "rx_trig_irq_o");
    chk(rts_no, m_rts, !auto_rts_en_i ? "R6" : (!rts_manual_i ? "R5" : "R4"), "rts_no");
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk(rts_no, 1, "R1", "rts_no in reset");
    chk(rx_trig_irq_o, 0, "R1", "irq in reset");
    rst_ni = 1'b1;
    step();
    chk(rts_no, 1, "R1", "rts_no after reset");

    // manual GPO with auto off, counts ignored
    rts_manual_i = 1'b1; rx_count_i = 7'd60; step();
    chk(rts_no, 0, "R6", "gpo asserted despite full fifo");
    rts_manual_i = 1'b0; step();
    chk(rts_no, 1, "R6", "gpo released");

    // auto on, manual not asserted: stays high
    auto_rts_en_i = 1'b1; rx_count_i = 7'd0; step();
    chk(rts_no, 1, "R5", "auto without manual assert");
    rts_manual_i = 1'b1; step();
    chk(rts_no, 0, "R5", "manual assert arms auto");

    // ramp up and down through hysteresis band
    for (int c = 0; c <= 64; c++) begin
      rx_count_i = 7'(c); step();
      if (c == 47) chk(rts_no, 0, "R3", "one below upper");
      if (c == 48) chk(rts_no, 1, "R3", "at upper threshold");
      if (c == 32) chk(rx_trig_irq_o, 1, "R2", "irq at trigger");
      if (c == 31) chk(rx_trig_irq_o, 0, "R2", "irq below trigger");
    end
    for (int c = 64; c >= 0; c--) begin
      rx_count_i = 7'(c); step();
      if (c == 16) chk(rts_no, 1, "R4", "held at lower threshold");
      if (c == 15) chk(rts_no, 0, "R4", "resumed below lower");
    end

    // halt, drop auto, re-enable inside the band
    rx_count_i = 7'd50; step();
    chk(rts_no, 1, "R3", "halted");
    auto_rts_en_i = 1'b0; rx_count_i = 7'd30; step();
    auto_rts_en_i = 1'b1; step();
    chk(rts_no, 0, "R10", "hysteresis cleared by disable");
    rx_count_i = 7'd55; step();
    rts_manual_i = 1'b0; step();
    rts_manual_i = 1'b1; rx_count_i = 7'd30; step();
    chk(rts_no, 0, "R10", "hysteresis cleared by manual drop");

    // clear-to-send gating
    tx_pending_i = 1'b1; tx_idle_i = 1'b1; auto_cts_en_i = 1'b1; cts_ni = 1'b1;
    step(); step(); step();
    chk(tx_start_o, 0, "R7", "blocked while cts high");
    cts_ni = 1'b0; step();
    chk(tx_start_o, 0, "R7", "sync latency one edge");
    step(); #1;
    chk(tx_start_o, 1, "R7", "released after two edges");
    @(negedge clk_i);
    tx_idle_i = 1'b0; step();
    chk(tx_start_o, 0, "R9", "no start while busy");
    tx_idle_i = 1'b1; auto_cts_en_i = 1'b0; cts_ni = 1'b1; step(); step(); #1;
    chk(tx_start_o, 1, "R8", "cts ignored when auto off");
    @(negedge clk_i);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int c = int'(rx_count_i) + int'($urandom_range(0, 6)) - 3;
      if (c < 0) c = 0;
      if (c > 64) c = 64;
      rx_count_i = 7'(c);
      if ($urandom_range(0, 49) == 0) auto_rts_en_i = ~auto_rts_en_i;
      if ($urandom_range(0, 49) == 0) auto_cts_en_i = ~auto_cts_en_i;
      if ($urandom_range(0, 29) == 0) rts_manual_i = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 199) == 0) begin
        hi_lvl_i   = 7'($urandom_range(8, 64));
        lo_lvl_i   = 7'($urandom_range(0, int'(hi_lvl_i) - 1));
        trig_lvl_i = ($urandom_range(0, 1) == 1) ? hi_lvl_i : 7'($urandom_range(1, 64));
      end
      cts_ni       = ($urandom_range(0, 3) == 0) ? ~cts_ni : cts_ni;
      tx_pending_i = 1'($urandom_range(0, 1));
      tx_idle_i    = ($urandom_range(0, 3) != 0);
      step();
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule